// File: doc/BRIEF.md
# Hierarchical Interrupt Status Register

This block holds the top-level interrupt register of a power manager with several regulator rails. Single-cycle event pulses set five sticky flags: load-current result ready, input overvoltage, thermal warning, thermal shutdown and external clock invalid. Software clears a flag by writing 1 to its bit. Two further bits are read-only summaries. Each one follows an interrupt sub-register kept for a pair of regulators. Bit 7 is a spare bit that software can read and write.

The register is reached over a simple register bus with address, write data, a write strobe and combinational read data. The active-high interrupt output is the OR of bits 0 to 6. While the latched thermal-shutdown flag is set, the block forces every regulator enable off and refuses enable requests.

Top module: `irq_status_hub`

## Requirements
- R1: After reset every register bit reads 0 and every rail enable is 0. The register answers at address 0x1A. A read at any other address returns 0x00, and a write to any other address changes nothing.
- R2: Each event pulse sets its sticky bit at the next clock edge. The mapping is: event 0 to bit 0 (load result ready), event 1 to bit 1 (input overvoltage), event 2 to bit 2 (thermal warning), event 3 to bit 3 (thermal shutdown), event 4 to bit 4 (clock invalid).
- R3: Writing 1 to a sticky bit (bits 0 to 4) at address 0x1A clears it at the next edge. Writing 0 leaves the bit as it was.
- R4: Bit 5 reads 1 exactly while the regulator-0/1 sub-register input is nonzero, and bit 6 reads 1 exactly while the regulator-2/3 sub-register input is nonzero. Both bits follow their inputs in the same cycle, and writes to bits 5 and 6 have no effect.
- R5: Bit 7 stores the value last written to it at address 0x1A.
- R6: At the edge where the thermal-shutdown bit (bit 3) becomes or stays set, all rail enables go to 0. Enable requests made while that bit is set are refused. Once the bit is cleared, a rail stays off until it receives a new enable request.
- R7: The interrupt output is high exactly when any of bits 0 to 6 reads 1.
- R8: If an event pulse and a write-one-to-clear reach the same sticky bit in the same cycle, the bit ends up set.
- R9: When the thermal-shutdown bit is clear, a rail-on pulse turns a rail's enable on and a rail-off pulse turns it off. If both pulses arrive in the same cycle, the rail turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, 0x00 when not addressed |
| evt_pulse | input | 5 | Event pulses, index equals sticky bit position |
| sub01_val | input | 8 | Contents of the regulator-0/1 interrupt sub-register |
| sub23_val | input | 8 | Contents of the regulator-2/3 interrupt sub-register |
| rail_on | input | 4 | Per-rail enable request pulses |
| rail_off | input | 4 | Per-rail disable request pulses |
| rail_en | output | 4 | Gated per-rail enables |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: four rails, 8-bit sub-registers and the register placed at 0x1A. With four rails, enable and disable pulses can overlap on some rails while other rails sit idle, so the off-wins rule and refusal under shutdown are seen on a mix of rails in one cycle. With the register at 0x1A, a neighbouring address is a true miss, which exercises the ignored writes and the zero read data.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int NSTK = 5;
    localparam int TSHUT_BIT = 3;

    typedef struct packed {
        logic [NSTK-1:0] stk;
    } stk_state_t;

    typedef struct packed {
        logic rsv;
    } top_state_t;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
    import irq_hub_pkg::*;
#(
    parameter int N = NSTK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q,
    output logic [N-1:0] d_next
);
    logic [N-1:0] st_d, st_q;

    always_comb begin
        st_d = (st_q & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q      = st_q;
    assign d_next = st_d;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> q[i]);
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr[i]) |=> q[i]);
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !q[i]);
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && evt[i]) |=> q[i]);
    end
endmodule

// File: rtl/irq_sub_flag.sv
module irq_sub_flag #(
    parameter int W    = 8,
    parameter int NSUB = 2
) (
    input  logic [NSUB*W-1:0] subs,
    output logic [NSUB-1:0]   flag
);
    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        assign flag[i] = |subs[i*W +: W];
    end
endmodule

// File: rtl/irq_rail_gate.sv
module irq_rail_gate #(
    parameter int NRAIL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             block_d,
    input  logic [NRAIL-1:0] on_req,
    input  logic [NRAIL-1:0] off_req,
    output logic [NRAIL-1:0] en
);
    typedef struct packed {
        logic [NRAIL-1:0] en;
    } gate_state_t;

    gate_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (block_d) s_d.en = '0;
        else         s_d.en = (s_q.en | on_req) & ~off_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en = s_q.en;

    p_block_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        block_d |=> (en == '0));

    for (genvar i = 0; i < NRAIL; i++) begin : g_chk
        p_off_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            off_req[i] |=> !en[i]);
        p_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (on_req[i] && !off_req[i] && !block_d) |=> en[i]);
    end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int AW       = 8,
    parameter int SUBW     = 8,
    parameter int NRAIL    = 4,
    parameter logic [AW-1:0] REG_ADDR = 8'h1A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    output logic [7:0]       bus_rdata,
    input  logic [NSTK-1:0]  evt_pulse,
    input  logic [SUBW-1:0]  sub01_val,
    input  logic [SUBW-1:0]  sub23_val,
    input  logic [NRAIL-1:0] rail_on,
    input  logic [NRAIL-1:0] rail_off,
    output logic [NRAIL-1:0] rail_en,
    output logic             irq
);
    localparam int NSUB = 2;

    logic            hit, wr;
    logic [NSTK-1:0] clr, stk_q, stk_d;
    logic [NSUB-1:0] flag;
    top_state_t      t_d, t_q;

    assign hit = (bus_addr == REG_ADDR);
    assign wr  = bus_we && hit;
    assign clr = wr ? bus_wdata[NSTK-1:0] : '0;

    irq_sticky_bank #(.N(NSTK)) u_stk (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(clr),
        .q(stk_q), .d_next(stk_d)
    );

    irq_sub_flag #(.W(SUBW), .NSUB(NSUB)) u_flag (
        .subs({sub23_val, sub01_val}), .flag(flag)
    );

    irq_rail_gate #(.NRAIL(NRAIL)) u_gate (
        .clk(clk), .rst_n(rst_n), .block_d(stk_d[TSHUT_BIT]),
        .on_req(rail_on), .off_req(rail_off), .en(rail_en)
    );

    always_comb begin
        t_d = t_q;
        if (wr) t_d.rsv = bus_wdata[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata = hit ? {t_q.rsv, flag[1], flag[0], stk_q} : 8'h00;
    assign irq       = (|stk_q) || (|flag);

    p_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (t_q.rsv == $past(bus_wdata[7])));
    p_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> (bus_rdata == 8'h00));
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq) |-> (stk_q == '0 && sub01_val == '0 && sub23_val == '0));
    p_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_wdata[6:5] != 2'b00 && sub01_val == '0 && sub23_val == '0)
        |-> (bus_rdata[6:5] == 2'b00));
endmodule

// File: tb/sim_irq_status_hub.sv
module sim_irq_status_hub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [4:0] evt_pulse = '0;
    logic [7:0] sub01_val = '0, sub23_val = '0;
    logic [3:0] rail_on = '0, rail_off = '0;
    logic [3:0] rail_en;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int seed = 32'h1d2c3b4a;

    logic [4:0] m_st = '0;
    logic       m_rsv = 1'b0;
    logic [3:0] m_en = '0;

    always #10 clk = ~clk;

    irq_status_hub u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .sub01_val(sub01_val), .sub23_val(sub23_val), .rail_on(rail_on),
        .rail_off(rail_off), .rail_en(rail_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rnd(input int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 32'h7fff) % m;
    endfunction

    task automatic step(input logic [7:0] a, input logic [7:0] wd, input logic we,
                        input logic [4:0] ev, input logic [7:0] s01, input logic [7:0] s23,
                        input logic [3:0] on, input logic [3:0] off);
        logic hit;
        logic [4:0] clr, st_n;
        logic [7:0] exp_rd;
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_we = we; evt_pulse = ev;
        sub01_val = s01; sub23_val = s23; rail_on = on; rail_off = off;
        #1;
        hit = (a == 8'h1A);
        exp_rd = hit ? {m_rsv, |s23, |s01, m_st} : 8'h00;
        if (hit) begin
            chk("R2 R3 R8 sticky bits", {3'b0, bus_rdata[4:0]}, {3'b0, exp_rd[4:0]});
            chk("R4 summary bits", {6'b0, bus_rdata[6:5]}, {6'b0, exp_rd[6:5]});
            chk("R5 spare bit", {7'b0, bus_rdata[7]}, {7'b0, exp_rd[7]});
        end else begin
            chk("R1 miss read", bus_rdata, 8'h00);
        end
        chk("R7 irq", {7'b0, irq}, {7'b0, (|m_st) | (|s01) | (|s23)});
        chk("R6 R9 rail enables", {4'b0, rail_en}, {4'b0, m_en});
        @(posedge clk);
        clr  = (we && hit) ? wd[4:0] : 5'b0;
        st_n = (m_st & ~clr) | ev;
        if (we && hit) m_rsv = wd[7];
        m_en = st_n[3] ? 4'b0 : ((m_en | on) & ~off);
        m_st = st_n;
    endtask

    task automatic idle();
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        #35;
        chk("R1 reset read", bus_rdata, 8'h00);
        chk("R1 reset enables", {4'b0, rail_en}, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        idle();
        // R2: each event on its own bit
        for (int i = 0; i < 5; i++) begin
            step(8'h1A, 8'h00, 1'b0, 5'(1 << i), 8'h00, 8'h00, 4'b0, 4'b0);
            idle();
        end
        // R3: write 0 keeps, write 1 clears
        step(8'h1A, 8'h00, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        step(8'h1A, 8'h15, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        // R1: miss write ignored
        step(8'h1B, 8'hFF, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        // R8: set and clear together
        step(8'h1A, 8'h02, 1'b1, 5'h02, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        step(8'h1A, 8'h1F, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        // R4: summaries follow, writes ignored
        step(8'h1A, 8'h60, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h80, 8'h00, 4'b0, 4'b0);
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h00, 8'h01, 4'b0, 4'b0);
        idle();
        // R5: spare bit
        step(8'h1A, 8'h80, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        step(8'h1A, 8'h00, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        // R9: on, off, off wins
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h00, 8'h00, 4'b1111, 4'b0);
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h00, 8'h00, 4'b0011, 4'b0110);
        idle();
        // R6: shutdown forces off, refuses, no auto-return
        step(8'h1A, 8'h00, 1'b0, 5'h08, 8'h00, 8'h00, 4'b1111, 4'b0);
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h00, 8'h00, 4'b1111, 4'b0);
        step(8'h1A, 8'h08, 1'b1, 5'b0, 8'h00, 8'h00, 4'b0, 4'b0);
        idle();
        step(8'h1A, 8'h00, 1'b0, 5'b0, 8'h00, 8'h00, 4'b0101, 4'b0);
        idle();
        // mixed stimulus against the model
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            a = (rnd(8) == 0) ? 8'(rnd(256)) : 8'h1A;
            step(a, 8'(rnd(256)), rnd(3) == 0,
                 (rnd(4) == 0) ? 5'(rnd(32)) : 5'b0,
                 (rnd(3) == 0) ? 8'(rnd(256)) : 8'h00,
                 (rnd(3) == 0) ? 8'(rnd(256)) : 8'h00,
                 4'(rnd(16)), (rnd(2) == 0) ? 4'(rnd(16)) : 4'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule